// File: doc/BRIEF.md
# Shifted-Operand ALU

A purely combinational 32-bit execution slice for register-register instructions whose second source is passed through a barrel shifter before the operation. A single 5-bit sub-opcode picks two things at once: the operation (add, subtract, AND, OR, XOR) and whether the second operand is shifted left or right. The shift amount is a 5-bit immediate in the range 0 to 31.

A bit-clear operation shares the same sub-opcode space. It never shifts its second operand. The block raises a valid flag only for recognised sub-opcodes, and forces the result to zero otherwise. The surrounding pipeline supplies register values that have already been read and the fields that have already been extracted. It writes the result back only when the valid flag is high.

Top module: `shift_alu`

## Requirements
- R1: `valid_o` is 1 exactly for sub-opcodes 00000, 00001, 00010, 00011, 00100, 11100, 11101, 11110, 11111, 10101 and 10010, and is 0 for every other code.
- R2: Left-shift codes compute `a_i op (b_i << shamt_i)`: 00000 add, 00001 subtract, 00010 AND, 00011 XOR, 00100 OR.
- R3: Right-shift codes compute `a_i op (b_i >> shamt_i)` with a logical shift that fills with zeros: 11100 add, 11101 subtract, 11110 AND, 11111 XOR, 10101 OR.
- R4: Add and subtract wrap modulo 2^32. Subtract is `a_i` minus the shifted operand. No carry or overflow is produced.
- R5: A shift amount of 0 leaves `b_i` unchanged. A shift amount of 31 moves only a single bit of `b_i` into the result.
- R6: Code 10010 gives `a_i & ~b_i`, and `shamt_i` has no effect on it.
- R7: For an unrecognised code, `result_o` is 0 and `valid_o` is 0.
- R8: The outputs follow the inputs combinationally, with no clock and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First source operand |
| b_i | input | 32 | Second source operand, shifted before use |
| shamt_i | input | 5 | Shift amount, 0 to 31 |
| subop_i | input | 5 | Sub-opcode selecting the operation and the shift direction |
| result_o | output | 32 | Operation result, zero when the code is unrecognised |
| valid_o | output | 1 | High when `subop_i` is a recognised code |

## Verification
The block holds no state, so any decode or shifter fault shows up at the ports in the same evaluation as the stimulus. A swapped direction bit or a mis-wired shifter stage corrupts the result only for shift amounts that exercise that stage. For that reason each stage bit is exercised alone, and shift amounts 0 and 31 are also covered. A decode slip between neighbouring codes shows up either as a flipped valid flag or as a result from the wrong operation. Every one of the 32 codes is therefore applied with operands that make all five operations give different results.

// File: rtl/shalu_pkg.sv
package shalu_pkg;
  localparam int SUBOP_W = 5;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_XOR,
    ALU_ANDN
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    shr;      // 1: logical right, 0: left
    logic    shift_en; // 0: operand b bypasses shifter
    logic    valid;
  } dec_t;
endpackage

// File: rtl/shalu_decode.sv
module shalu_decode
  import shalu_pkg::*;
(
  input  logic [SUBOP_W-1:0] subop_i,
  output dec_t               dec_o
);
  always_comb begin
    dec_o = '{op: ALU_ADD, shr: 1'b0, shift_en: 1'b1, valid: 1'b1};
    unique case (subop_i)
      5'b00000: dec_o.op = ALU_ADD;
      5'b00001: dec_o.op = ALU_SUB;
      5'b00010: dec_o.op = ALU_AND;
      5'b00011: dec_o.op = ALU_XOR;
      5'b00100: dec_o.op = ALU_OR;
      5'b11100: begin dec_o.op = ALU_ADD; dec_o.shr = 1'b1; end
      5'b11101: begin dec_o.op = ALU_SUB; dec_o.shr = 1'b1; end
      5'b11110: begin dec_o.op = ALU_AND; dec_o.shr = 1'b1; end
      5'b11111: begin dec_o.op = ALU_XOR; dec_o.shr = 1'b1; end
      5'b10101: begin dec_o.op = ALU_OR;  dec_o.shr = 1'b1; end
      5'b10010: begin dec_o.op = ALU_ANDN; dec_o.shift_en = 1'b0; end
      default:  dec_o.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/shalu_shifter.sv
module shalu_shifter #(
  parameter int DATA_W  = 32,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               shr_i,
  output logic [DATA_W-1:0]  data_o
);
  logic [DATA_W-1:0] stg [SHAMT_W+1];

  assign stg[0] = data_i;

  // log2 stages, stage k moves by 2**k
  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    always_comb begin
      if (!amt_i[k])   stg[k+1] = stg[k];
      else if (shr_i)  stg[k+1] = stg[k] >> STEP;
      else             stg[k+1] = stg[k] << STEP;
    end
  end

  assign data_o = stg[SHAMT_W];
endmodule

// File: rtl/shalu_core.sv
module shalu_core
  import shalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD:  res_o = a_i + b_i;
      ALU_SUB:  res_o = a_i - b_i;
      ALU_AND:  res_o = a_i & b_i;
      ALU_OR:   res_o = a_i | b_i;
      ALU_XOR:  res_o = a_i ^ b_i;
      ALU_ANDN: res_o = a_i & ~b_i;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/shift_alu.sv
module shift_alu
  import shalu_pkg::*;
#(
  parameter int DATA_W  = 32,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [SUBOP_W-1:0] subop_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               valid_o
);
  dec_t               dec;
  logic [SHAMT_W-1:0] amt;
  logic [DATA_W-1:0]  b_sh;
  logic [DATA_W-1:0]  core_res;

  shalu_decode u_dec (
    .subop_i (subop_i),
    .dec_o   (dec)
  );

  assign amt = dec.shift_en ? shamt_i : '0;

  shalu_shifter #(.DATA_W(DATA_W)) u_shf (
    .data_i (b_i),
    .amt_i  (amt),
    .shr_i  (dec.shr),
    .data_o (b_sh)
  );

  shalu_core #(.DATA_W(DATA_W)) u_core (
    .op_i  (dec.op),
    .a_i   (a_i),
    .b_i   (b_sh),
    .res_o (core_res)
  );

  assign result_o = dec.valid ? core_res : '0;
  assign valid_o  = dec.valid;
endmodule

// File: rtl/shift_alu_chk.sv
module shift_alu_chk #(
  parameter int DATA_W  = 32,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0]  a_i,
  input logic [DATA_W-1:0]  b_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic [4:0]         subop_i,
  input logic [DATA_W-1:0]  result_o,
  input logic               valid_o
);
  always_comb begin
    // R7
    invalid_zero_chk: assert (valid_o || result_o == '0)
      else $error("result not zero for unrecognised code");
    // R6
    bitclr_chk: assert (subop_i != 5'b10010 || (valid_o && result_o == (a_i & ~b_i)))
      else $error("bit clear mismatch");
    // R1
    legal_valid_chk: assert (subop_i != 5'b00000 || valid_o)
      else $error("add-left not flagged valid");
    // R5
    zero_shift_chk: assert (!(subop_i == 5'b00011 && shamt_i == '0) || result_o == (a_i ^ b_i))
      else $error("zero shift altered operand");
    // R3
    right_fill_chk: assert (subop_i != 5'b11110 || (result_o & ~a_i) == '0)
      else $error("right AND set bits outside a");
  end
endmodule

bind shift_alu shift_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .shamt_i  (shamt_i),
  .subop_i  (subop_i),
  .result_o (result_o),
  .valid_o  (valid_o)
);

// File: tb/shift_alu_test.sv
module shift_alu_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [4:0]  sh = '0, code = '0;
  logic [31:0] res;
  logic        vld;
  int          n_vec = 0, n_bad = 0;

  always #4 clk = ~clk; // 125 MHz

  shift_alu uut (
    .a_i(a), .b_i(b), .shamt_i(sh), .subop_i(code),
    .result_o(res), .valid_o(vld)
  );

  function automatic logic [32:0] model(logic [31:0] x, logic [31:0] y,
                                        logic [4:0] s, logic [4:0] c);
    longint unsigned l = 64'(y << s), r = 64'(y >> s);
    longint unsigned m = 64'hFFFF_FFFF;
    case (c)
      5'b00000: return {1'b1, 32'((x + l) & m)};
      5'b00001: return {1'b1, 32'((64'(x) + 64'h1_0000_0000 - l) & m)};
      5'b00010: return {1'b1, x & 32'(l)};
      5'b00011: return {1'b1, x ^ 32'(l)};
      5'b00100: return {1'b1, x | 32'(l)};
      5'b11100: return {1'b1, 32'((x + r) & m)};
      5'b11101: return {1'b1, 32'((64'(x) + 64'h1_0000_0000 - r) & m)};
      5'b11110: return {1'b1, x & 32'(r)};
      5'b11111: return {1'b1, x ^ 32'(r)};
      5'b10101: return {1'b1, x | 32'(r)};
      5'b10010: return {1'b1, x & ~y};
      default:  return 33'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [4:0] c);
    case (c)
      5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b00100: return "R2";
      5'b11100, 5'b11101, 5'b11110, 5'b11111, 5'b10101: return "R3";
      5'b10010: return "R6";
      default:  return "R7";
    endcase
  endfunction

  task automatic apply(input logic [31:0] x, input logic [31:0] y,
                       input logic [4:0] s, input logic [4:0] c, input string rq);
    logic [32:0] exp;
    @(negedge clk);
    a = x; b = y; sh = s; code = c;
    #1; // R8: no clock edge between drive and sample
    exp = model(x, y, s, c);
    n_vec++;
    if ({vld, res} !== exp) begin
      n_bad++;
      $display("FAIL %s code=%b sh=%0d a=%h b=%h: got v=%b r=%h, expected v=%b r=%h",
               rq, c, s, x, y, vld, res, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset-state inputs: all zero, add-left, result 0
    apply(32'h0, 32'h0, 5'd0, 5'd0, "R1");
    // R2 left variants
    apply(32'h0000_1000, 32'h0000_0003, 5'd4, 5'b00000, "R2");
    apply(32'hF0F0_F0F0, 32'h0000_00FF, 5'd8, 5'b00010, "R2");
    apply(32'h1234_5678, 32'h0000_0F0F, 5'd12, 5'b00011, "R2");
    apply(32'h0000_0001, 32'h0000_0001, 5'd16, 5'b00100, "R2");
    // R3 right variants, zero fill from a set top bit
    apply(32'h0000_0010, 32'h8000_0000, 5'd4, 5'b11100, "R3");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd28, 5'b11110, "R3");
    apply(32'h0000_0000, 32'hF000_0000, 5'd1, 5'b10101, "R3");
    apply(32'hAAAA_AAAA, 32'hFFFF_0000, 5'd16, 5'b11111, "R3");
    // R4 wrap-around on add and subtract
    apply(32'hFFFF_FFFF, 32'h0000_0001, 5'd0, 5'b00000, "R4");
    apply(32'h0000_0000, 32'h0000_0001, 5'd0, 5'b00001, "R4");
    apply(32'h0000_0005, 32'h0000_0004, 5'd1, 5'b11101, "R4");
    apply(32'h8000_0000, 32'h0000_0001, 5'd31, 5'b00000, "R4");
    // R5 shift 0 and 31
    apply(32'h0, 32'hDEAD_BEEF, 5'd0, 5'b00100, "R5");
    apply(32'h0, 32'hDEAD_BEEF, 5'd0, 5'b10101, "R5");
    apply(32'h0, 32'hFFFF_FFFF, 5'd31, 5'b00100, "R5");
    apply(32'h0, 32'hFFFF_FFFF, 5'd31, 5'b10101, "R5");
    // R6 bit clear ignores the shift amount
    apply(32'hFFFF_FFFF, 32'h0F0F_0F0F, 5'd0, 5'b10010, "R6");
    apply(32'hFFFF_FFFF, 32'h0F0F_0F0F, 5'd17, 5'b10010, "R6");
    // every shifter stage alone, both directions
    for (int k = 0; k < 5; k++) begin
      apply(32'h0, 32'h0001_8001, 5'(1 << k), 5'b00011, "R2");
      apply(32'h0, 32'h8001_8000, 5'(1 << k), 5'b11111, "R3");
    end
    // R1 / R7 all 32 codes, operands that separate every operation
    for (int c = 0; c < 32; c++) begin
      apply(32'h9C3A_5E71, 32'h6B2D_8F14, 5'd3, 5'(c), "R1");
      apply(32'h9C3A_5E71, 32'h6B2D_8F14, 5'd3, 5'(c), tag_of(5'(c)));
    end
    // mixed random sweep
    for (int i = 0; i < 2000; i++) begin
      logic [4:0] c;
      c = 5'($urandom);
      apply($urandom, $urandom, 5'($urandom), c, tag_of(c));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule